// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running supervision counter meant to be clocked from a 32.768 kHz low-speed clock. Once the block leaves reset the counter runs, and no input can stop it. Software must service it by writing a two-value key sequence. If an interval passes without service, the block raises a one-cycle non-maskable interrupt request. If the next interval also passes without service, the block drives a system reset pulse several cycles wide.

The interval comes from a fixed table of seven lengths. The lengths are multiples of a base count. With the default base of 256 cycles, the table holds 768, 1024, 2048, 4096, 16384, 65536 and 262144 cycles. At 32.768 kHz these are about 23.4 ms, 31.25 ms, 62.5 ms, 125 ms, 500 ms, 2 s and 8 s. The period select input is latched only when a valid service happens. A change to it therefore cannot shorten the interval that is already running and so cannot cause an early overflow. After a reset, or after the block's own reset pulse, the block is back at stage zero with the longest interval.

Top module: `wdog_escalator`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `nmi_req` and `sys_rst_o` are low. The block starts at stage zero with the default interval, period code 6 (1024 x BASE_CYCLES cycles).
- R2: Period code to interval in clock cycles: 0 gives 3, 1 gives 4, 2 gives 8, 3 gives 16, 4 gives 64, 5 gives 256 and 6 gives 1024 times BASE_CYCLES. Code 7 is treated as code 6.
- R3: When a full interval of L cycles passes at stage zero with no service, `nmi_req` is high for exactly one cycle. It is first seen after the L-th clock edge counted from the start point, and `sys_rst_o` stays low.
- R4: When a second interval of L cycles passes with no service after an interrupt, `sys_rst_o` is high for exactly RST_CYCLES cycles. It is first seen after edge 2L, and no interrupt is raised for that overflow.
- R5: A valid service is a key write of KEY_A (0x5A) whose next key write is KEY_B (0xA5). Idle cycles may lie between the two writes. Service restarts the count and clears the stage, so the next interrupt comes L edges after the KEY_B edge, and no reset follows the earlier interrupt.
- R6: Any other key write has no effect on timing. This covers KEY_B with no KEY_A just before it, other values, and KEY_A followed by a wrong value and then KEY_B.
- R7: A new `period_sel` value takes effect only at the next valid service.
- R8: After the reset pulse ends, the block is at stage zero with the default interval, and the next interrupt comes 1024 x BASE_CYCLES edges later. Key writes made while the pulse is high are ignored.
- R9: If a valid service falls on the same edge as an overflow, the service wins and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 3 | Interval code, latched when a valid service happens |
| key_wr | input | 1 | Key write strobe |
| key_data | input | 8 | Key value written |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The checker tests these on every cycle:
- the interrupt lasts a single cycle;
- the interrupt and the reset are never high together;
- a reset pulse only starts from the armed stage and always has the set width;
- the counter never passes its terminal count;
- the latched interval code only changes on a valid service or at the start of a reset pulse.

Only the bench scenarios can show the exact interval lengths for each period code. The same holds for the key-sequence rules: rejected orderings, idle gaps and writes during the pulse. The bench scenarios also cover the service that falls on an overflow edge and the default interval after a reset pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned KEY_W = 8;
    localparam logic [2:0]  SEL_DEFAULT = 3'd6;

    // Interval length in units of the base count
    function automatic int unsigned period_mult(input logic [2:0] code);
        case (code)
            3'd0:    period_mult = 3;
            3'd1:    period_mult = 4;
            3'd2:    period_mult = 8;
            3'd3:    period_mult = 16;
            3'd4:    period_mult = 64;
            3'd5:    period_mult = 256;
            default: period_mult = 1024;
        endcase
    endfunction

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
    parameter int unsigned         KW    = 8,
    parameter logic [KW-1:0]       KEY_A = 8'h5A,
    parameter logic [KW-1:0]       KEY_B = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [KW-1:0] data,
    input  logic          block,
    output logic          hit
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        if (block)
            armed_d = 1'b0;
        else if (wr)
            armed_d = (data == KEY_A);
    end

    assign hit = wr && !block && armed_q && (data == KEY_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/wdog_period_lut.sv
module wdog_period_lut #(
    parameter int unsigned BASE_CYCLES = 256,
    parameter int unsigned CW          = 18
) (
    input  logic [2:0]    sel,
    output logic [CW-1:0] term
);
    import wdog_pkg::*;

    always_comb begin
        term = CW'(period_mult(sel) * BASE_CYCLES - 1);
    end
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator #(
    parameter int unsigned BASE_CYCLES = 256,
    parameter int unsigned RST_CYCLES  = 8,
    parameter logic [7:0]  KEY_A       = 8'h5A,
    parameter logic [7:0]  KEY_B       = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] period_sel,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       nmi_req,
    output logic       sys_rst_o
);
    import wdog_pkg::*;

    localparam int unsigned CW = $clog2(1024 * BASE_CYCLES);
    localparam int unsigned PW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          stage;
        logic          nmi;
        logic [2:0]    sel;
        logic [PW-1:0] pulse;
    } wd_state_t;

    wd_state_t     st_d, st_q;
    logic [CW-1:0] term;
    logic          clr;
    logic          in_pulse;

    assign in_pulse = (st_q.pulse != '0);

    wdog_key_seq #(
        .KW   (KEY_W),
        .KEY_A(KEY_A),
        .KEY_B(KEY_B)
    ) u_keys (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (key_wr),
        .data (key_data),
        .block(in_pulse),
        .hit  (clr)
    );

    wdog_period_lut #(
        .BASE_CYCLES(BASE_CYCLES),
        .CW         (CW)
    ) u_lut (
        .sel (st_q.sel),
        .term(term)
    );

    always_comb begin
        st_d     = st_q;
        st_d.nmi = 1'b0;
        if (in_pulse) begin
            st_d.pulse = st_q.pulse - 1'b1;
            st_d.cnt   = '0;
        end else if (clr) begin
            st_d.cnt   = '0;
            st_d.stage = 1'b0;
            st_d.sel   = period_sel;
        end else if (st_q.cnt == term) begin
            st_d.cnt = '0;
            if (!st_q.stage) begin
                st_d.stage = 1'b1;
                st_d.nmi   = 1'b1;
            end else begin
                st_d.stage = 1'b0;
                st_d.sel   = SEL_DEFAULT;
                st_d.pulse = PW'(RST_CYCLES);
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, stage: 1'b0, nmi: 1'b0, sel: SEL_DEFAULT, pulse: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_req   = st_q.nmi;
    assign sys_rst_o = in_pulse;
endmodule

// File: rtl/wdog_escalator_chk.sv
module wdog_escalator_chk #(
    parameter int unsigned RST_CYCLES = 8,
    parameter int unsigned CW         = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nmi_req,
    input logic          sys_rst_o,
    input logic          stage,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] term,
    input logic [2:0]    sel,
    input logic          clr
);
    logic [15:0] width_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         width_q <= '0;
        else if (sys_rst_o) width_q <= width_q + 1'b1;
        else                width_q <= '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!nmi_req && !sys_rst_o));

    // R3
    nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    // R4
    nmi_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_req && sys_rst_o));

    // R4
    rst_from_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(stage));

    // R4
    rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (width_q == 16'(RST_CYCLES)));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= term);

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !stage && !nmi_req));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel) |-> ($past(clr) || $rose(sys_rst_o)));
endmodule

bind wdog_escalator wdog_escalator_chk #(
    .RST_CYCLES(RST_CYCLES),
    .CW        (CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_req  (nmi_req),
    .sys_rst_o(sys_rst_o),
    .stage    (st_q.stage),
    .cnt      (st_q.cnt),
    .term     (term),
    .sel      (st_q.sel),
    .clr      (clr)
);

// File: tb/sim_wdog_escalator.sv
module sim_wdog_escalator;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 4;
    localparam int PULSE = 8;
    localparam logic [7:0] KA = 8'h5A;
    localparam logic [7:0] KB = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] period_sel = 3'd6;
    logic       key_wr = 1'b0;
    logic [7:0] key_data = 8'h00;
    logic       nmi_req, sys_rst_o;

    int checks = 0;
    int fails = 0;
    bit any_nmi = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_escalator #(.BASE_CYCLES(BASE), .RST_CYCLES(PULSE), .KEY_A(KA), .KEY_B(KB)) u0 (
        .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .key_wr(key_wr),
        .key_data(key_data), .nmi_req(nmi_req), .sys_rst_o(sys_rst_o)
    );

    function automatic int exp_len(input int code);
        int m;
        case (code)
            0: m = 3;  1: m = 4;  2: m = 8;  3: m = 16;
            4: m = 64; 5: m = 256; default: m = 1024;
        endcase
        return m * BASE;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit wr, input logic [7:0] d);
        key_wr = wr;
        key_data = d;
        @(posedge clk);
        @(negedge clk);
        key_wr = 1'b0;
        if (nmi_req) any_nmi = 1;
    endtask

    task automatic do_clear();
        step(1, KA);
        step(1, KB);
    endtask

    task automatic wait_event(output int n, output bit got_nmi, output bit got_rst);
        n = 0; got_nmi = 0; got_rst = 0;
        while (!got_nmi && !got_rst && n < 20000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            got_nmi = nmi_req;
            got_rst = sys_rst_o;
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 nmi in reset", int'(nmi_req), 0);
        chk("R1 rst in reset", int'(sys_rst_o), 0);
        rst_n = 1'b1;
    endtask

    // R1 R3 R4 R8: unserviced escalation from reset
    task automatic t_escalation();
        int n, w; bit gn, gr;
        period_sel = 3'd0;
        apply_reset();
        wait_event(n, gn, gr);
        chk("R1 default interval to nmi", n, exp_len(6));
        chk("R3 nmi seen", int'(gn), 1);
        chk("R3 no reset at first overflow", int'(gr), 0);
        step(0, 8'h00);
        chk("R3 nmi one cycle", int'(nmi_req), 0);
        wait_event(n, gn, gr);
        chk("R4 second overflow edges", n + 1, exp_len(6));
        chk("R4 reset seen", int'(gr), 1);
        chk("R4 no nmi at second overflow", int'(gn), 0);
        w = 1;
        step(1, KA); if (sys_rst_o) w++;
        step(1, KB); if (sys_rst_o) w++;
        while (sys_rst_o && w < 100) begin
            step(0, 8'h00);
            if (sys_rst_o) w++;
        end
        chk("R4 reset pulse width", w, PULSE);
        wait_event(n, gn, gr);
        chk("R8 default interval after pulse, keys in pulse ignored", n, exp_len(6));
        chk("R8 nmi after pulse", int'(gn), 1);
    endtask

    // R2 R5: each period code, service at stage one prevents reset
    task automatic t_periods();
        int n; bit gn, gr;
        for (int c = 0; c < 8; c++) begin
            period_sel = 3'(c);
            do_clear();
            wait_event(n, gn, gr);
            chk($sformatf("R2 interval code %0d", c), n, exp_len(c));
            chk($sformatf("R5 nmi not reset code %0d", c), int'(gr), 0);
        end
    endtask

    // R5 R6: rejected key orderings and a gapped valid pair
    task automatic t_keys();
        int n, m; bit gn, gr;
        period_sel = 3'd2;
        do_clear();
        n = 0;
        repeat (5) begin step(0, 8'h00); n++; end
        step(1, KB); n++;
        step(1, 8'h33); n++;
        step(1, KA); n++;
        step(1, 8'h00); n++;
        step(1, KB); n++;
        wait_event(m, gn, gr);
        chk("R6 bad keys leave timing", n + m, exp_len(2));
        period_sel = 3'd1;
        step(1, KA);
        repeat (3) step(0, 8'h00);
        step(1, KB);
        wait_event(n, gn, gr);
        chk("R5 gapped key pair services", n, exp_len(1));
    endtask

    // R7: select change without service is not used
    task automatic t_late_sel();
        int n; bit gn, gr;
        period_sel = 3'd3;
        do_clear();
        period_sel = 3'd0;
        wait_event(n, gn, gr);
        chk("R7 old interval kept", n, exp_len(3));
        do_clear();
        wait_event(n, gn, gr);
        chk("R7 new interval after service", n, exp_len(0));
    endtask

    // R9: service on the overflow edge wins
    task automatic t_coincide();
        int n; bit gn, gr;
        period_sel = 3'd0;
        do_clear();
        any_nmi = 0;
        repeat (exp_len(0) - 2) step(0, 8'h00);
        step(1, KA);
        step(1, KB);
        chk("R9 no nmi on coincident service", int'(any_nmi), 0);
        wait_event(n, gn, gr);
        chk("R9 count restarted at coincident edge", n, exp_len(0));
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        t_escalation();
        t_periods();
        t_keys();
        t_late_sel();
        t_coincide();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule